// File: doc/BRIEF.md
# Indirect-Access Statistics Counter Bank

The block keeps a bank of per-port frame statistics counters and one shared drop-packet counter per port, all reached by a host through a small byte-wide register window. Frame-level logic elsewhere raises one-cycle increment pulses. Each per-port pulse carries the number of the counter to bump. Each drop pulse bumps the drop counter of its port.

The host fetches a counter in two steps. First it writes a table code to the table register, and then it writes a counter index to the index register. The index write starts a fetch. The holding word goes to zero at once. A fixed number of cycles later the holding word takes the selected value, and the host then reads it as four byte registers.

Per-port counters are cleared when the fetch captures them. They wrap at their width and keep a sticky overflow flag until they are next read. Drop counters are never cleared and carry no flags, so the host has to detect their wrap itself.

Top module: `stats_bank`

## Requirements
- R1: After reset every counter is zero and all four data bytes (addresses 4 to 7) read 0x00.
- R2: Address 0 holds the table code: 0x01 selects the per-port table and 0x02 selects the drop table. A write to address 1 with either code in place starts a fetch. With any other code the index write is ignored and the data bytes keep their value.
- R3: The clock edge that takes the index write sets the holding word to zero, so the valid bit reads 0. The edge FETCH_LAT cycles after it loads the fetched value.
- R4: A per-port result word has overflow at bit 31, valid (1) at bit 30 and the count zero-extended in bits 29:0. The word reads at addresses 4, 5, 6 and 7, most significant byte first.
- R5: A per-port index puts the port in bits 7:5 and the counter number in bits 4:0, so the port stride is 0x20. An index whose port is at or above NUM_PORTS, or whose counter is at or above CNT_PER_PORT, returns 0x40000000 and changes no counter.
- R6: Fetching a per-port counter clears its count and its overflow flag.
- R7: A per-port count wraps modulo 2^CNT_W. The wrap sets the overflow flag, and the flag stays set until the next fetch of that counter.
- R8: An increment that arrives in the same cycle as the clearing fetch of that counter leaves the count at 1.
- R9: A drop-table fetch uses the port number as index. It returns the drop count zero-extended, with bits 31:16 zero. It never clears the count, which wraps modulo 2^DROP_W. An index at or above NUM_PORTS returns 0.
- R10: An index write while a fetch is pending restarts the wait. Only the last index is fetched, and only that counter is cleared.
- R11: An increment pulse whose counter number is at or above CNT_PER_PORT changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 3 | Host register address (0 table, 1 index, 4..7 data bytes) |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Data byte at hostAddr, combinational |
| incPulse | input | NUM_PORTS | Per-port statistics increment pulses |
| incSel | input | 5*NUM_PORTS | Counter number for each port's pulse, 5 bits per port |
| dropPulse | input | NUM_PORTS | Per-port drop counter increment pulses |

## Verification
The bench builds the block with three ports, six counters per port, 4-bit counts, 5-bit drop counters and a fetch latency of three cycles. The narrow counts let a short pulse train wrap both kinds of counter, so the sticky overflow flag and the silent drop wrap can be observed. The short latency lets the bench place an increment exactly in the clearing cycle and overlap two index writes. With six counters per port, counter numbers 6 to 31 act as out-of-range indices and ignored increments.

// File: rtl/stats_pkg.sv
package stats_pkg;
  localparam logic [7:0] TBL_PORT = 8'h01;
  localparam logic [7:0] TBL_DROP = 8'h02;
  localparam int SEL_W = 5;

  typedef struct packed {
    logic       start;
    logic       latch;
    logic       selPort;
    logic       selDrop;
    logic [7:0] idx;
  } ctrlStrobe_t;
endpackage

// File: rtl/stats_ctrl.sv
module stats_ctrl import stats_pkg::*; #(
  parameter int FETCH_LAT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [2:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  output ctrlStrobe_t strb
);
  localparam int WAIT_W = $clog2(FETCH_LAT + 1);

  logic [7:0]        tblReg;
  logic [7:0]        pendTbl;
  logic [7:0]        pendIdx;
  logic [WAIT_W-1:0] waitCnt;
  logic              idxWr;
  logic              codeOk;
  logic              startNow;

  assign idxWr    = hostWrEn && (hostAddr == 3'd1);
  assign codeOk   = (tblReg == TBL_PORT) || (tblReg == TBL_DROP);
  assign startNow = idxWr && codeOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tblReg  <= '0;
      pendTbl <= '0;
      pendIdx <= '0;
      waitCnt <= '0;
    end else begin
      if (hostWrEn && hostAddr == 3'd0) tblReg <= hostWrData;
      if (startNow) begin
        pendTbl <= tblReg;
        pendIdx <= hostWrData;
        waitCnt <= WAIT_W'(FETCH_LAT);
      end else if (waitCnt != '0) begin
        waitCnt <= waitCnt - WAIT_W'(1);
      end
    end
  end

  always_comb begin
    strb.start   = startNow;
    strb.latch   = !startNow && (waitCnt == WAIT_W'(1));
    strb.selPort = (pendTbl == TBL_PORT);
    strb.selDrop = (pendTbl == TBL_DROP);
    strb.idx     = pendIdx;
  end
endmodule

// File: rtl/stats_datapath.sv
module stats_datapath import stats_pkg::*; #(
  parameter int NUM_PORTS    = 4,
  parameter int CNT_PER_PORT = 32,
  parameter int CNT_W        = 30,
  parameter int DROP_W       = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strb,
  input  logic [NUM_PORTS-1:0]       incPulse,
  input  logic [NUM_PORTS*SEL_W-1:0] incSel,
  input  logic [NUM_PORTS-1:0]       dropPulse,
  output logic [31:0]                holdWord
);
  logic [CNT_W-1:0]  cnt    [NUM_PORTS][CNT_PER_PORT];
  logic              ovf    [NUM_PORTS][CNT_PER_PORT];
  logic              incHit [NUM_PORTS][CNT_PER_PORT];
  logic              clrHit [NUM_PORTS][CNT_PER_PORT];
  logic [DROP_W-1:0] dropCnt[NUM_PORTS];

  logic [2:0]        rdPort;
  logic [4:0]        rdCnt;
  logic              portHit;
  logic              dropHit;
  logic [CNT_W-1:0]  selCnt;
  logic              selOvf;
  logic [DROP_W-1:0] selDrop;

  assign rdPort = strb.idx[7:5];
  assign rdCnt  = strb.idx[4:0];

  always_comb begin
    portHit = 1'b0;
    selCnt  = '0;
    selOvf  = 1'b0;
    dropHit = 1'b0;
    selDrop = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int c = 0; c < CNT_PER_PORT; c++) begin
        incHit[p][c] = incPulse[p] && (incSel[p*SEL_W +: SEL_W] == SEL_W'(c));
        clrHit[p][c] = strb.latch && strb.selPort &&
                       (rdPort == 3'(p)) && (rdCnt == 5'(c));
        if (rdPort == 3'(p) && rdCnt == 5'(c)) begin
          portHit = 1'b1;
          selCnt  = cnt[p][c];
          selOvf  = ovf[p][c];
        end
      end
      if (strb.idx == 8'(p)) begin
        dropHit = 1'b1;
        selDrop = dropCnt[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        dropCnt[p] <= '0;
        for (int c = 0; c < CNT_PER_PORT; c++) begin
          cnt[p][c] <= '0;
          ovf[p][c] <= 1'b0;
        end
      end
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (dropPulse[p]) dropCnt[p] <= dropCnt[p] + DROP_W'(1);
        for (int c = 0; c < CNT_PER_PORT; c++) begin
          if (clrHit[p][c]) begin
            cnt[p][c] <= incHit[p][c] ? CNT_W'(1) : '0;
            ovf[p][c] <= 1'b0;
          end else if (incHit[p][c]) begin
            cnt[p][c] <= cnt[p][c] + CNT_W'(1);
            if (&cnt[p][c]) ovf[p][c] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
    end else if (strb.start) begin
      holdWord <= '0;
    end else if (strb.latch) begin
      if (strb.selPort)
        holdWord <= portHit ? {selOvf, 1'b1, 30'(selCnt)} : 32'h4000_0000;
      else if (strb.selDrop)
        holdWord <= dropHit ? 32'(selDrop) : '0;
    end
  end
endmodule

// File: rtl/stats_bank.sv
module stats_bank import stats_pkg::*; #(
  parameter int NUM_PORTS    = 4,
  parameter int CNT_PER_PORT = 32,
  parameter int CNT_W        = 30,
  parameter int DROP_W       = 16,
  parameter int FETCH_LAT    = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWrEn,
  input  logic [2:0]                 hostAddr,
  input  logic [7:0]                 hostWrData,
  output logic [7:0]                 hostRdData,
  input  logic [NUM_PORTS-1:0]       incPulse,
  input  logic [NUM_PORTS*SEL_W-1:0] incSel,
  input  logic [NUM_PORTS-1:0]       dropPulse
);
  ctrlStrobe_t strb;
  logic [31:0] holdWord;

  stats_ctrl #(.FETCH_LAT(FETCH_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .strb(strb)
  );

  stats_datapath #(
    .NUM_PORTS(NUM_PORTS), .CNT_PER_PORT(CNT_PER_PORT),
    .CNT_W(CNT_W), .DROP_W(DROP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .incPulse(incPulse),
    .incSel(incSel), .dropPulse(dropPulse), .holdWord(holdWord)
  );

  always_comb begin
    case (hostAddr)
      3'd4:    hostRdData = holdWord[31:24];
      3'd5:    hostRdData = holdWord[23:16];
      3'd6:    hostRdData = holdWord[15:8];
      3'd7:    hostRdData = holdWord[7:0];
      default: hostRdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/stats_bank_chk.sv
module stats_bank_chk import stats_pkg::*; #(
  parameter int DROP_W = 16
) (
  input logic        clk,
  input logic        rstN,
  input ctrlStrobe_t strb,
  input logic [31:0] holdWord
);
  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> holdWord == 32'h0);

  p_port_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch && strb.selPort |=> holdWord[30]);

  p_drop_noflags_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch && strb.selDrop |=> holdWord[31:DROP_W] == '0);

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.start && !strb.latch |=> $stable(holdWord));

  p_valid_after_latch_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdWord[30]) |-> $past(strb.latch));
endmodule

bind stats_bank stats_bank_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .holdWord(holdWord)
);

// File: tb/test_stats_bank.sv
module test_stats_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int NC = 6;
  localparam int CW = 4;
  localparam int DW = 5;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostWrEn = 1'b0;
  logic [2:0]    hostAddr = 3'd4;
  logic [7:0]    hostWrData = 8'h00;
  logic [7:0]    hostRdData;
  logic [NP-1:0] incPulse = '0;
  logic [NP*5-1:0] incSel = '0;
  logic [NP-1:0] dropPulse = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stats_bank #(.NUM_PORTS(NP), .CNT_PER_PORT(NC), .CNT_W(CW), .DROP_W(DW),
               .FETCH_LAT(LAT)) i_stats_bank (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .incPulse(incPulse),
    .incSel(incSel), .dropPulse(dropPulse)
  );

  // behavioural reference model
  int          mCnt [NP][NC];
  bit          mOvf [NP][NC];
  int          mDrop[NP];
  logic [31:0] mHold = 0;
  int          mWait = 0;
  logic [7:0]  mTbl = 0, mPTbl = 0, mPIdx = 0;
  bit          mSt, mLa, mInc;
  int          mPp, mCc, clrP, clrC;
  logic [31:0] mW;

  initial begin
    for (int p = 0; p < NP; p++) begin
      mDrop[p] = 0;
      for (int c = 0; c < NC; c++) begin mCnt[p][c] = 0; mOvf[p][c] = 0; end
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NP; p++) begin
        mDrop[p] = 0;
        for (int c = 0; c < NC; c++) begin mCnt[p][c] = 0; mOvf[p][c] = 0; end
      end
      mHold = 0; mWait = 0; mTbl = 0; mPTbl = 0; mPIdx = 0;
    end else begin
      mSt = hostWrEn && hostAddr == 3'd1 && (mTbl == 8'h01 || mTbl == 8'h02);
      mLa = !mSt && mWait == 1;
      mPp = mPIdx / 32; mCc = mPIdx % 32; clrP = -1; clrC = -1; mW = 0;
      if (mLa) begin
        if (mPTbl == 8'h01) begin
          if (mPp < NP && mCc < NC) begin
            mW = {mOvf[mPp][mCc], 1'b1, 30'(mCnt[mPp][mCc])};
            clrP = mPp; clrC = mCc;
          end else mW = 32'h4000_0000;
        end else if (mPIdx < NP) mW = 32'(mDrop[mPIdx]);
      end
      for (int p = 0; p < NP; p++) begin
        if (dropPulse[p]) mDrop[p] = (mDrop[p] + 1) % (1 << DW);
        for (int c = 0; c < NC; c++) begin
          mInc = incPulse[p] && (incSel[p*5 +: 5] == 5'(c));
          if (p == clrP && c == clrC) begin
            mCnt[p][c] = mInc ? 1 : 0; mOvf[p][c] = 0;
          end else if (mInc) begin
            if (mCnt[p][c] == (1 << CW) - 1) begin mCnt[p][c] = 0; mOvf[p][c] = 1; end
            else mCnt[p][c] = mCnt[p][c] + 1;
          end
        end
      end
      if (mSt) begin mHold = 0; mPTbl = mTbl; mPIdx = hostWrData; mWait = LAT; end
      else begin
        if (mLa) mHold = mW;
        if (mWait > 0) mWait = mWait - 1;
      end
      if (hostWrEn && hostAddr == 3'd0) mTbl = hostWrData;
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    logic [7:0] e;
    #2;
    if (rstN && !done) begin
      case (hostAddr)
        3'd4: e = mHold[31:24];
        3'd5: e = mHold[23:16];
        3'd6: e = mHold[15:8];
        3'd7: e = mHold[7:0];
        default: e = 8'h00;
      endcase
      total++;
      if (hostRdData !== e) begin
        bad++;
        $display("FAIL R4 model compare addr=%0d actual=%h expected=%h", hostAddr, hostRdData, e);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0; hostAddr = 3'd4;
  endtask

  task automatic fetch(input logic [7:0] idx);
    hostWr(3'd1, idx);
    repeat (LAT) @(negedge clk);
  endtask

  task automatic readWord(output logic [31:0] w);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      hostAddr = 3'(4 + i);
      #1 w[31-8*i -: 8] = hostRdData;
    end
  endtask

  task automatic incN(input int p, input int c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      incPulse[p] = 1'b1; incSel[p*5 +: 5] = 5'(c);
      @(negedge clk);
      incPulse = '0;
    end
  endtask

  task automatic dropN(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); dropPulse[p] = 1'b1;
      @(negedge clk); dropPulse = '0;
    end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readWord(w); chk("R1 reset word", w, 32'h0);
    hostWr(3'd0, 8'h01);
    fetch(8'h00); readWord(w); chk("R1 counter zero after reset", w, 32'h4000_0000);

    // R11 / R4 basic increments
    incN(0, 2, 3); incN(1, 2, 5);
    fetch(8'h02); readWord(w); chk("R4 port0 ctr2", w, 32'h4000_0003);
    fetch(8'h02); readWord(w); chk("R6 cleared on read", w, 32'h4000_0000);
    fetch(8'h22); readWord(w); chk("R5 stride 0x20 port1 ctr2", w, 32'h4000_0005);

    // R7 wrap and sticky overflow
    incN(2, 1, 17);
    fetch(8'h41); readWord(w); chk("R7 wrap sets overflow", w, 32'hC000_0001);
    fetch(8'h41); readWord(w); chk("R6 overflow cleared by read", w, 32'h4000_0000);

    // R3 valid timing
    hostWr(3'd1, 8'h22);
    hostAddr = 3'd4; #1 chk("R3 valid low after index write", 32'(hostRdData), 32'h0);
    @(negedge clk); @(negedge clk);
    #1 chk("R3 still pending", 32'(hostRdData), 32'h0);
    @(negedge clk);
    #1 chk("R3 valid after latency", 32'(hostRdData), 32'h40);

    // R8 same-cycle increment and clear
    incN(0, 3, 2);
    hostWr(3'd1, 8'h03);
    @(negedge clk); @(negedge clk);
    incPulse[0] = 1'b1; incSel[0 +: 5] = 5'd3;
    @(negedge clk); incPulse = '0;
    readWord(w); chk("R8 fetched value", w, 32'h4000_0002);
    fetch(8'h03); readWord(w); chk("R8 coincident event kept", w, 32'h4000_0001);

    // R11 ignored counter number, R5 out of range
    incN(0, 7, 1);
    fetch(8'h01); readWord(w); chk("R11 ignored increment", w, 32'h4000_0000);
    fetch(8'h07); readWord(w); chk("R5 counter out of range", w, 32'h4000_0000);
    fetch(8'h60); readWord(w); chk("R5 port out of range", w, 32'h4000_0000);

    // R9 drop counters
    dropN(1, 35);
    hostWr(3'd0, 8'h02);
    fetch(8'h05); readWord(w); chk("R9 drop index out of range", w, 32'h0);
    fetch(8'h01); readWord(w); chk("R9 drop wrap no flags", w, 32'h0000_0003);
    fetch(8'h01); readWord(w); chk("R9 drop not cleared", w, 32'h0000_0003);

    // R2 bad table code ignored
    hostWr(3'd0, 8'h07);
    fetch(8'h01); readWord(w); chk("R2 bad table ignored", w, 32'h0000_0003);

    // R10 restart
    hostWr(3'd0, 8'h01);
    incN(2, 0, 2); incN(2, 4, 4);
    hostWr(3'd1, 8'h40);
    fetch(8'h44); readWord(w); chk("R10 last index fetched", w, 32'h4000_0004);
    fetch(8'h40); readWord(w); chk("R10 first index not cleared", w, 32'h4000_0002);
    fetch(8'h44); readWord(w); chk("R10 last index cleared", w, 32'h4000_0000);

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule